// File: doc/BRIEF.md
# Mailbox Threshold Interrupt Controller

This block serves one side of an inter-processor mailbox. It watches the fill level of the outgoing (send) FIFO, the fill level of the incoming (receive) FIFO and the mailbox error flags. From these it drives one level-sensitive interrupt line towards the local processor. Software sets a send threshold and a receive threshold. Each threshold defines an "active" condition. When that condition goes from false to true, a sticky event bit is latched in an interrupt status register.

The status bits are acknowledged by writing ones to them. A per-bit enable mask selects which latched events are allowed to reach the interrupt line. The read-only pending view is the AND of status and enable, and the interrupt output is the OR of the pending bits. Writing a new threshold value can on its own produce an active-condition edge, and so an event. All registers sit on a simple single-cycle register bus: a write strobe with address and data, and a combinational read data return selected by the address.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: The send-active condition is true when the send level is less than or equal to the send threshold. Its rising edge sets status bit 0 (send event) on the clock edge at which the new condition is first seen. A falling edge sets nothing.
- R2: The receive-active condition is true when the receive level is strictly greater than the receive threshold. Its rising edge sets status bit 1 (receive event). A level equal to the threshold is not active.
- R3: A write that changes a threshold so that its active condition becomes true sets the matching status bit one cycle after the write, with no change of level.
- R4: Status bit 2 (error event) is set on every clock edge at which any error flag input is 1. It stays set after the flags return to 0.
- R5: Writing the status register at offset 0x20 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: The enable register at offset 0x24 resets to 0. It is read/write in bits 2..0 (same layout as status), and its other bits read 0.
- R8: Offset 0x28 reads status AND enable. Writes to it change no register.
- R9: The interrupt output is 1 exactly when any bit of status AND enable is 1.
- R10: The send threshold (offset 0x18) and the receive threshold (offset 0x1C) reset to 0. Each stores only the low log2(DEPTH) bits of write data and reads back zero-extended. Unmapped offsets read 0.
- R11: After reset no event is latched for an active condition that is already true at the reset-time levels and thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_lvl | input | $clog2(DEPTH+1) | Current send-FIFO fill level |
| recv_lvl | input | $clog2(DEPTH+1) | Current receive-FIFO fill level |
| err_flags | input | ERR_W | Mailbox error flags, any 1 raises the error event |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr |
| irq_o | output | 1 | Level interrupt to the local processor |

## Verification
The bench uses the defaults: DEPTH of 16 (4-bit thresholds, 5-bit levels), a 32-bit data bus, an 8-bit address and two error flags. With 4-bit thresholds, the boundary levels (equal to the threshold, one above it) and the masking of wide write data down to the low bits can all be reached with small values. With two error flags, the bench can show that either flag alone raises the error event.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  // register byte offsets
  localparam int OFS_SEND_THR = 'h18;
  localparam int OFS_RECV_THR = 'h1C;
  localparam int OFS_STATUS   = 'h20;
  localparam int OFS_ENABLE   = 'h24;
  localparam int OFS_PENDING  = 'h28;

  // event bit positions, shared by status, enable and pending
  localparam int EV_SEND = 0;
  localparam int EV_RECV = 1;
  localparam int EV_ERR  = 2;
  localparam int NUM_EV  = 3;

  // comparator selection for a level/threshold watcher
  typedef enum logic {CMP_AT_OR_BELOW = 1'b0, CMP_ABOVE = 1'b1} cmp_mode_e;

  function automatic logic send_active(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction

  function automatic logic recv_active(input int unsigned lvl, input int unsigned thr);
    return lvl > thr;
  endfunction

  // next status: set wins over write-one-to-clear
  function automatic logic [NUM_EV-1:0] status_next(input logic [NUM_EV-1:0] cur,
                                                    input logic [NUM_EV-1:0] clr,
                                                    input logic [NUM_EV-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mbox_thr_reg.sv
module mbox_thr_reg #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [THR_W-1:0] wdata,
  output logic [THR_W-1:0] thr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     thr_o <= '0;
    else if (wr_en) thr_o <= wdata;
  end
endmodule

// File: rtl/mbox_lvl_edge.sv
module mbox_lvl_edge
  import mbox_irq_pkg::*;
#(
  parameter int        LVL_W = 5,
  parameter int        THR_W = 4,
  parameter cmp_mode_e MODE  = CMP_AT_OR_BELOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic [THR_W-1:0] thr,
  output logic             active_o,
  output logic             rise_o
);
  logic active_q;

  generate
    if (MODE == CMP_AT_OR_BELOW) begin : g_below
      assign active_o = send_active(32'(lvl), 32'(thr));
    end else begin : g_above
      assign active_o = recv_active(32'(lvl), 32'(thr));
    end
  endgenerate

  // during reset the history follows the live condition, so the
  // first cycle after reset sees no artificial edge
  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= active_o;
    else        active_q <= active_o;
  end

  assign rise_o = rst_n && active_o && !active_q;
endmodule

// File: rtl/mbox_irq_status.sv
module mbox_irq_status
  import mbox_irq_pkg::*;
#(
  parameter int N = NUM_EV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         st_wr,
  input  logic         en_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] status_o,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] pending_o
);
  logic [N-1:0] clr;
  assign clr = st_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      status_o <= status_next(status_o, clr, set_i);
      if (en_wr) enable_o <= wbits;
    end
  end

  assign pending_o = status_o & enable_o;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ERR_W  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  send_lvl,
  input  logic [LVL_W-1:0]  recv_lvl,
  input  logic [ERR_W-1:0]  err_flags,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  // named internal events, observed by the bound checker
  logic             wr_send_thr, wr_recv_thr, wr_status, wr_enable;
  logic [THR_W-1:0] send_thr, recv_thr;
  logic             send_act, recv_act, send_rise, recv_rise, err_any;
  logic [NUM_EV-1:0] ev_set, status_q, enable_q, pending;

  assign wr_send_thr = bus_wr && (bus_addr == ADDR_W'(OFS_SEND_THR));
  assign wr_recv_thr = bus_wr && (bus_addr == ADDR_W'(OFS_RECV_THR));
  assign wr_status   = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
  assign wr_enable   = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));

  mbox_thr_reg #(.THR_W(THR_W)) u_send_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_send_thr),
    .wdata(bus_wdata[THR_W-1:0]), .thr_o(send_thr)
  );

  mbox_thr_reg #(.THR_W(THR_W)) u_recv_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_recv_thr),
    .wdata(bus_wdata[THR_W-1:0]), .thr_o(recv_thr)
  );

  mbox_lvl_edge #(.LVL_W(LVL_W), .THR_W(THR_W), .MODE(CMP_AT_OR_BELOW)) u_send_edge (
    .clk(clk), .rst_n(rst_n), .lvl(send_lvl), .thr(send_thr),
    .active_o(send_act), .rise_o(send_rise)
  );

  mbox_lvl_edge #(.LVL_W(LVL_W), .THR_W(THR_W), .MODE(CMP_ABOVE)) u_recv_edge (
    .clk(clk), .rst_n(rst_n), .lvl(recv_lvl), .thr(recv_thr),
    .active_o(recv_act), .rise_o(recv_rise)
  );

  assign err_any = |err_flags;

  always_comb begin
    ev_set          = '0;
    ev_set[EV_SEND] = send_rise;
    ev_set[EV_RECV] = recv_rise;
    ev_set[EV_ERR]  = err_any;
  end

  mbox_irq_status #(.N(NUM_EV)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set),
    .st_wr(wr_status), .en_wr(wr_enable), .wbits(bus_wdata[NUM_EV-1:0]),
    .status_o(status_q), .enable_o(enable_q), .pending_o(pending)
  );

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFS_SEND_THR: bus_rdata = DATA_W'(send_thr);
      OFS_RECV_THR: bus_rdata = DATA_W'(recv_thr);
      OFS_STATUS:   bus_rdata = DATA_W'(status_q);
      OFS_ENABLE:   bus_rdata = DATA_W'(enable_q);
      OFS_PENDING:  bus_rdata = DATA_W'(pending);
      default:      bus_rdata = '0;
    endcase
  end

  assign irq_o = |pending;
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ERR_W-1:0]  err_flags,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              send_rise,
  input logic              recv_rise,
  input logic [2:0]        status_q,
  input logic [2:0]        enable_q,
  input logic              irq_o
);
  // R1
  send_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_rise |=> status_q[0]);
  // R2
  recv_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recv_rise |=> status_q[1]);
  // R4
  err_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_flags) |=> status_q[2]);
  // R5
  send_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h20) && bus_wdata[0] && !send_rise) |=> !status_q[0]);
  // R8
  pending_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h28)) |=> ($stable(enable_q) && ($past(status_q) & ~status_q) == 3'b000));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((status_q & enable_q) != 3'b000));
endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .send_rise(send_rise),
  .recv_rise(recv_rise), .status_q(status_q), .enable_q(enable_q), .irq_o(irq_o)
);

// File: tb/sim_mbox_irq_ctrl.sv
module sim_mbox_irq_ctrl;
  localparam int DEPTH = 16, ERR_W = 2, ADDR_W = 8, DATA_W = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0]  send_lvl = '0, recv_lvl = '0;
  logic [ERR_W-1:0]  err_flags = '0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  mbox_irq_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .send_lvl(send_lvl), .recv_lvl(recv_lvl),
    .err_flags(err_flags), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [7:0] A_SEND = 8'h18, A_RECV = 8'h1C, A_ST = 8'h20, A_EN = 8'h24, A_PD = 8'h28;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    chk(req, {31'b0, irq_o}, {31'b0, exp});
  endtask

  task automatic set_send(input int v); @(negedge clk); send_lvl = LVL_W'(v); endtask
  task automatic set_recv(input int v); @(negedge clk); recv_lvl = LVL_W'(v); endtask

  // reset with receive condition already true (3 > 0) and send true (0 <= 0)
  task automatic t_reset;
    rd_chk("R11 no event after reset", A_ST, 0);
    rd_chk("R10 send thr reset", A_SEND, 0);
    rd_chk("R10 recv thr reset", A_RECV, 0);
    rd_chk("R7 enable reset", A_EN, 0);
    rd_chk("R8 pending reset", A_PD, 0);
    irq_chk("R9 irq reset", 1'b0);
    rd_chk("R10 unmapped reads 0", 8'h00, 0);
  endtask

  task automatic t_thr;
    wr(A_SEND, 32'hFFFF_FFF5);
    rd_chk("R10 send thr low bits", A_SEND, 5);
    wr(A_RECV, 32'hABCD_EF07);
    rd_chk("R10 recv thr low bits", A_RECV, 7);
    rd_chk("R1 no event on fall", A_ST, 0);
  endtask

  task automatic t_send;
    set_send(8);
    rd_chk("R1 above thr no event", A_ST, 0);
    set_send(5);
    rd_chk("R1 equal thr rises", A_ST, 1);
    rd_chk("R8 pending masked", A_PD, 0);
    irq_chk("R9 masked irq low", 1'b0);
    wr(A_EN, 32'h0000_0001);
    rd_chk("R7 enable readback", A_EN, 1);
    rd_chk("R8 pending and", A_PD, 1);
    irq_chk("R9 irq high", 1'b1);
    wr(A_ST, 32'h0000_0000);
    rd_chk("R5 write zero keeps", A_ST, 1);
    wr(A_ST, 32'h0000_0001);
    rd_chk("R5 write one clears", A_ST, 0);
    irq_chk("R9 irq low after clear", 1'b0);
  endtask

  task automatic t_recv;
    set_recv(7);
    rd_chk("R2 equal thr inactive", A_ST, 0);
    set_recv(8);
    rd_chk("R2 above thr rises", A_ST, 2);
    irq_chk("R9 recv masked", 1'b0);
    wr(A_ST, 32'h0000_0002);
    rd_chk("R5 clear recv", A_ST, 0);
  endtask

  task automatic t_thrwrite;
    wr(A_RECV, 9);
    rd_chk("R3 raise recv thr no event", A_ST, 0);
    wr(A_RECV, 3);
    rd_chk("R3 recv thr write event", A_ST, 2);
    wr(A_SEND, 2);
    wr(A_ST, 32'h0000_0003);
    rd_chk("R3 send thr drop no event", A_ST, 0);
    wr(A_SEND, 12);
    rd_chk("R3 send thr write event", A_ST, 1);
    wr(A_ST, 32'h0000_0003);
    rd_chk("R5 clear both", A_ST, 0);
  endtask

  task automatic t_err;
    @(negedge clk); err_flags = 2'b01;
    @(negedge clk); err_flags = 2'b00;
    rd_chk("R4 err sticky", A_ST, 4);
    wr(A_EN, 32'hFFFF_FFFC);
    rd_chk("R7 enable upper bits read 0", A_EN, 4);
    irq_chk("R9 err irq", 1'b1);
    @(negedge clk); err_flags = 2'b10;
    wr(A_ST, 32'h0000_0004);
    rd_chk("R6 err held wins over clear", A_ST, 4);
    @(negedge clk); err_flags = 2'b00;
    wr(A_ST, 32'h0000_0004);
    rd_chk("R4 err cleared once flags low", A_ST, 0);
    irq_chk("R9 irq low", 1'b0);
  endtask

  task automatic t_setwins;
    set_send(14);
    @(negedge clk);
    send_lvl = LVL_W'(3);
    bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd_chk("R6 send set wins", A_ST, 1);
    wr(A_ST, 32'h1);
    rd_chk("R5 clear after set wins", A_ST, 0);
  endtask

  task automatic t_pending_ro;
    set_send(14);
    set_send(3);
    rd_chk("R1 event for ro test", A_ST, 1);
    wr(A_PD, 32'h0000_0007);
    rd_chk("R8 pending write leaves enable", A_EN, 4);
    rd_chk("R8 pending write leaves status", A_ST, 1);
    rd_chk("R8 pending value", A_PD, 0);
    wr(A_EN, 32'h0000_0005);
    rd_chk("R8 pending after enable", A_PD, 1);
    irq_chk("R9 irq from send", 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    recv_lvl = LVL_W'(3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_thr();
    t_send();
    t_recv();
    t_thrwrite();
    t_err();
    t_setwins();
    t_pending_ro();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule